// File: doc/BRIEF.md
# Dual-Channel DAC Host Register Interface

This block is the host-facing register file for a converter with two 10-bit output channels, Main and Sub. A host writes over a parallel bus: a 10-bit data word, a 2-bit address and a write strobe. The strobe is synchronised into the system clock. A small state machine turns each strobe rising edge into exactly one one-cycle commit pulse. A combinational decoder maps that pulse onto the register it targets: the system control register, one channel's control settings, the data-channel select, or the high and low parts of a channel's code.

Two write modes exist. In full-width mode a data write loads all ten bits of the channel chosen by a stored select bit. In byte mode an 8-bit host drives only `wr_data[9:2]`. The two low bus bits then act as control lines. DB0 picks the target and DB1 picks the half of the code. The block drives, for each channel, a registered output code, an enable, the clear flag and a 2-bit bias-source select.

The strobe state machine has three states. ST_IDLE waits for the synchronised strobe to be high and then moves to ST_COMMIT. ST_COMMIT lasts one cycle, raises the commit pulse and always moves to ST_HOLD. ST_HOLD waits for the synchronised strobe to go low and then returns to ST_IDLE.

Top module: `dac_pair_regif`

## Requirements
- R1: After reset, system standby is set, power-down is clear, byte mode is off and the coding select is zero. Both enables are low and both codes are zero. Both clear flags are low and both bias selects are 00. The data-channel select points to Main.
- R2: Each rising edge of `wr_strobe`, sampled through a two-flop synchroniser, produces exactly one commit. Holding the strobe high produces no further update.
- R3: A write to address 0 with DB0=0 loads the system control register from four data bits: bit 9 is power-down, bit 8 is system standby, bit 7 is byte mode and bit 6 is the coding select. A write to address 0 with DB0=1 loads a channel's settings from these data bits: bit 9 is the target channel (0 for Main, 1 for Sub), bit 8 is standby, bit 7 is clear and bits 6:5 are the bias select. In full-width mode the same write also stores bit 9 as the data-channel select.
- R4: In full-width mode, a write to address 1 loads all ten data bits into the channel named by the data-channel select.
- R5: In byte mode, address-0 writes choose their target with DB0 exactly as in R3, and DB1 is ignored. Writing byte mode back to 0 returns the interface to full-width mode.
- R6: In byte mode, a write to address 1 takes the channel from DB0 (0 for Main, 1 for Sub). DB1=0 loads code bits 9:2 from `wr_data[9:2]`. DB1=1 loads code bits 1:0 from `wr_data[3:2]`. Byte-mode control writes leave the data-channel select unchanged.
- R7: Writes to address 2 or 3 change nothing.
- R8: A channel's enable is high only when system standby, power-down and that channel's standby are all clear.
- R9: Data writes are accepted and stored while in standby or power-down.
- R10: While a channel's clear flag is set, its output code is zero. The stored code is kept and reappears when the flag is cleared.
- R11: With the coding select at 1, the output code is the stored code with bit 9 inverted. With the coding select at 0, the stored code is output unchanged.
- R12: In byte mode, the two halves of a code update independently. A write to one half leaves the other half as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_strobe | input | 1 | Host write strobe; a rising edge requests one write |
| wr_addr | input | 2 | 0 selects the control registers, 1 selects the data registers |
| wr_data | input | 10 | Host write data |
| main_code | output | 10 | Registered output code, Main channel |
| main_en | output | 1 | Main channel enable |
| main_clr | output | 1 | Main channel clear flag |
| main_bias | output | 2 | Main channel bias-source select |
| sub_code | output | 10 | Registered output code, Sub channel |
| sub_en | output | 1 | Sub channel enable |
| sub_clr | output | 1 | Sub channel clear flag |
| sub_bias | output | 2 | Sub channel bias-source select |

## Verification
The hardest state to reach is one where byte-mode writes have changed state that is not visible on the outputs. One case is a stored code hidden behind the clear flag or standby. The other is a data-channel select that a byte-mode control write must leave alone. The stimulus reaches these cases in several steps. It loads a code while in standby, or sets clear over a known code, and then releases the condition to show the code that was stored. For the select, it writes a channel-control word with the opposite target bit while in byte mode, returns to full-width mode, and issues a full data write. Where that write lands shows whether the select changed.

// File: rtl/dac_regif_pkg.sv
package dac_regif_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_HOLD   = 2'd2
    } wr_state_t;

    localparam int unsigned CH_MAIN = 0;
    localparam int unsigned CH_SUB  = 1;
    localparam int unsigned NUM_CH  = 2;
endpackage

// File: rtl/dac_strobe_fsm.sv
module dac_strobe_fsm
    import dac_regif_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic commit
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   strobe_s;
    wr_state_t              state_q, state_d;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= strobe_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_in};
            end
        end
    endgenerate

    assign strobe_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            ST_IDLE:   if (strobe_s) state_d = ST_COMMIT;
            ST_COMMIT: begin
                commit  = 1'b1;
                state_d = ST_HOLD;
            end
            ST_HOLD:   if (!strobe_s) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // R2: one commit per strobe, never back to back
    assert_single_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
    // R2: a held strobe parks the machine in ST_HOLD
    assert_hold_while_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && strobe_s) |=> (state_q == ST_HOLD));
endmodule

// File: rtl/dac_write_decode.sv
module dac_write_decode
    import dac_regif_pkg::*;
#(
    parameter int unsigned CODE_W   = 10,
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned CTL_ADDR = 0,
    parameter int unsigned DAT_ADDR = 1
) (
    input  logic              commit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CODE_W-1:0] data,
    input  logic              byte_mode,
    input  logic              chan_sel,
    output logic              sys_we,
    output logic              sel_we,
    output logic [NUM_CH-1:0] chc_we,
    output logic [NUM_CH-1:0] hi_we,
    output logic [NUM_CH-1:0] lo_we,
    output logic [CODE_W-3:0] hi_val,
    output logic [1:0]        lo_val
);
    logic is_ctl, is_dat, ctl_hit, tgt, dch;

    always_comb begin
        is_ctl  = commit && (addr == ADDR_W'(CTL_ADDR));
        is_dat  = commit && (addr == ADDR_W'(DAT_ADDR));
        sys_we  = is_ctl && !data[0];
        ctl_hit = is_ctl && data[0];
        tgt     = data[CODE_W-1];
        sel_we  = ctl_hit && !byte_mode;
        dch     = byte_mode ? data[0] : chan_sel;
        hi_val  = data[CODE_W-1:2];
        lo_val  = byte_mode ? data[3:2] : data[1:0];
        for (int c = 0; c < NUM_CH; c++) begin
            chc_we[c] = ctl_hit && (tgt == c[0]);
            hi_we[c]  = is_dat && (dch == c[0]) && (!byte_mode || !data[1]);
            lo_we[c]  = is_dat && (dch == c[0]) && (!byte_mode ||  data[1]);
        end
    end
endmodule

// File: rtl/dac_chan_slot.sv
module dac_chan_slot #(
    parameter int unsigned CODE_W = 10,
    parameter int unsigned MUX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              stby_in,
    input  logic              clr_in,
    input  logic [MUX_W-1:0]  mux_in,
    input  logic              hi_we,
    input  logic [CODE_W-3:0] hi_val,
    input  logic              lo_we,
    input  logic [1:0]        lo_val,
    input  logic              sys_off,
    input  logic              coding,
    output logic [CODE_W-1:0] code_o,
    output logic              en_o,
    output logic              clr_o,
    output logic [MUX_W-1:0]  bias_o
);
    localparam logic [CODE_W-1:0] MSB_FLIP = {1'b1, {(CODE_W-1){1'b0}}};

    logic              stby_q, clr_q;
    logic [MUX_W-1:0]  mux_q;
    logic [CODE_W-3:0] hi_q;
    logic [1:0]        lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stby_q <= 1'b0;
            clr_q  <= 1'b0;
            mux_q  <= '0;
        end else if (ctl_we) begin
            stby_q <= stby_in;
            clr_q  <= clr_in;
            mux_q  <= mux_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_q <= '0;
        else if (hi_we) hi_q <= hi_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     lo_q <= '0;
        else if (lo_we) lo_q <= lo_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o <= '0;
            en_o   <= 1'b0;
        end else begin
            code_o <= clr_q ? '0 : ({hi_q, lo_q} ^ (coding ? MSB_FLIP : '0));
            en_o   <= !sys_off && !stby_q;
        end
    end

    assign clr_o  = clr_q;
    assign bias_o = mux_q;

    assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |=> (code_o == '0));
    assert_off_disables_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_off || stby_q) |=> !en_o);
    assert_hi_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_we |=> $stable(hi_q));
    assert_lo_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_we |=> $stable(lo_q));
endmodule

// File: rtl/dac_pair_regif.sv
module dac_pair_regif
    import dac_regif_pkg::*;
#(
    parameter int unsigned CODE_W      = 10,
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned MUX_W       = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    output logic [CODE_W-1:0] main_code,
    output logic              main_en,
    output logic              main_clr,
    output logic [MUX_W-1:0]  main_bias,
    output logic [CODE_W-1:0] sub_code,
    output logic              sub_en,
    output logic              sub_clr,
    output logic [MUX_W-1:0]  sub_bias
);
    localparam int unsigned B_PD    = CODE_W - 1;
    localparam int unsigned B_SSTBY = CODE_W - 2;
    localparam int unsigned B_BYTE  = CODE_W - 3;
    localparam int unsigned B_CODE  = CODE_W - 4;
    localparam int unsigned B_STBY  = CODE_W - 2;
    localparam int unsigned B_CLR   = CODE_W - 3;
    localparam int unsigned B_MUXHI = CODE_W - 4;

    logic              commit;
    logic              pd_q, sstby_q, byte_q, coding_q, sel_q;
    logic              sys_we, sel_we;
    logic [NUM_CH-1:0] chc_we, hi_we, lo_we;
    logic [CODE_W-3:0] hi_val;
    logic [1:0]        lo_val;

    logic [CODE_W-1:0] code_a [NUM_CH];
    logic [MUX_W-1:0]  bias_a [NUM_CH];
    logic [NUM_CH-1:0] en_a, clr_a;

    dac_strobe_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_in (wr_strobe),
        .commit    (commit)
    );

    dac_write_decode #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_dec (
        .commit    (commit),
        .addr      (wr_addr),
        .data      (wr_data),
        .byte_mode (byte_q),
        .chan_sel  (sel_q),
        .sys_we    (sys_we),
        .sel_we    (sel_we),
        .chc_we    (chc_we),
        .hi_we     (hi_we),
        .lo_we     (lo_we),
        .hi_val    (hi_val),
        .lo_val    (lo_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_q     <= 1'b0;
            sstby_q  <= 1'b1;
            byte_q   <= 1'b0;
            coding_q <= 1'b0;
        end else if (sys_we) begin
            pd_q     <= wr_data[B_PD];
            sstby_q  <= wr_data[B_SSTBY];
            byte_q   <= wr_data[B_BYTE];
            coding_q <= wr_data[B_CODE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_q <= 1'b0;
        else if (sel_we) sel_q <= wr_data[CODE_W-1];
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            dac_chan_slot #(.CODE_W(CODE_W), .MUX_W(MUX_W)) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .ctl_we  (chc_we[c]),
                .stby_in (wr_data[B_STBY]),
                .clr_in  (wr_data[B_CLR]),
                .mux_in  (wr_data[B_MUXHI -: MUX_W]),
                .hi_we   (hi_we[c]),
                .hi_val  (hi_val),
                .lo_we   (lo_we[c]),
                .lo_val  (lo_val),
                .sys_off (sstby_q || pd_q),
                .coding  (coding_q),
                .code_o  (code_a[c]),
                .en_o    (en_a[c]),
                .clr_o   (clr_a[c]),
                .bias_o  (bias_a[c])
            );
        end
    endgenerate

    assign main_code = code_a[CH_MAIN];
    assign main_en   = en_a[CH_MAIN];
    assign main_clr  = clr_a[CH_MAIN];
    assign main_bias = bias_a[CH_MAIN];
    assign sub_code  = code_a[CH_SUB];
    assign sub_en    = en_a[CH_SUB];
    assign sub_clr   = clr_a[CH_SUB];
    assign sub_bias  = bias_a[CH_SUB];

    assert_bad_addr_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr > ADDR_W'(1)) |-> !(sys_we || sel_we || (|chc_we) || (|hi_we) || (|lo_we)));
    assert_one_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sys_we, |chc_we, |(hi_we | lo_we)}));
    assert_byte_sel_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_q |=> $stable(sel_q));
    assert_standby_en_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sstby_q |=> !(main_en || sub_en));
endmodule

// File: tb/dac_pair_regif_tb.sv
module dac_pair_regif_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_strobe = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [9:0] wr_data = '0;
    logic [9:0] main_code, sub_code;
    logic       main_en, sub_en, main_clr, sub_clr;
    logic [1:0] main_bias, sub_bias;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dac_pair_regif u_dut (
        .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
        .wr_data(wr_data), .main_code(main_code), .main_en(main_en),
        .main_clr(main_clr), .main_bias(main_bias), .sub_code(sub_code),
        .sub_en(sub_en), .sub_clr(sub_clr), .sub_bias(sub_bias)
    );

    // reference model
    bit       m_pd, m_sstby, m_byte, m_coding, m_sel;
    bit       m_stby [2];
    bit       m_clr  [2];
    bit [1:0] m_mx   [2];
    bit [9:0] m_dat  [2];

    typedef struct {
        logic [27:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sbq[$];

    function automatic logic [27:0] expected();
        logic [9:0] c [2];
        logic       e [2];
        for (int i = 0; i < 2; i++) begin
            c[i] = m_clr[i] ? 10'd0 : (m_dat[i] ^ (m_coding ? 10'h200 : 10'h000));
            e[i] = !m_sstby && !m_pd && !m_stby[i];
        end
        return {c[0], e[0], m_clr[0], m_mx[0], c[1], e[1], m_clr[1], m_mx[1]};
    endfunction

    task automatic model_write(input logic [1:0] a, input logic [9:0] d);
        int ch;
        if (a == 2'd0) begin
            if (!d[0]) begin
                m_pd = d[9]; m_sstby = d[8]; m_byte = d[7]; m_coding = d[6];
            end else begin
                ch = d[9];
                m_stby[ch] = d[8]; m_clr[ch] = d[7]; m_mx[ch] = d[6:5];
                if (!m_byte) m_sel = d[9];
            end
        end else if (a == 2'd1) begin
            if (!m_byte) m_dat[m_sel] = d;
            else begin
                ch = d[0];
                if (!d[1]) m_dat[ch][9:2] = d[9:2];
                else       m_dat[ch][1:0] = d[3:2];
            end
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [9:0] d, input int hold = 4);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_strobe = 1'b1;
        repeat (hold) @(negedge clk);
        wr_strobe = 1'b0;
        repeat (4) @(negedge clk);
        model_write(a, d);
    endtask

    task automatic expect_now(input string tag);
        sb_item_t it;
        @(negedge clk);
        it.exp = expected();
        it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                sb_item_t it;
                logic [27:0] act;
                it = sbq.pop_front();
                act = {main_code, main_en, main_clr, main_bias,
                       sub_code, sub_en, sub_clr, sub_bias};
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_pd = 0; m_sstby = 1; m_byte = 0; m_coding = 0; m_sel = 0;
        for (int i = 0; i < 2; i++) begin
            m_stby[i] = 0; m_clr[i] = 0; m_mx[i] = 2'b00; m_dat[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        expect_now("R1 reset state");

        bus_write(2'd0, 10'b0000000000);          // leave standby
        expect_now("R3 R8 standby cleared, enables up");
        bus_write(2'd0, 10'b0001000001);          // main ctl: mx=10
        expect_now("R3 main bias select");
        bus_write(2'd0, 10'b1000100001);          // sub ctl: mx=01, select sub
        expect_now("R3 sub bias select");
        bus_write(2'd1, 10'h2A5, 12);             // long strobe, one write
        expect_now("R4 R2 full write to sub");
        bus_write(2'd0, 10'b0001000001);          // select main
        bus_write(2'd1, 10'h13C);
        expect_now("R4 full write to main");
        bus_write(2'd2, 10'h3FF);
        bus_write(2'd3, 10'h001);
        expect_now("R7 addresses 2 and 3 ignored");
        bus_write(2'd0, 10'b0001000000);          // coding=1
        expect_now("R11 coding select flips bit 9");
        bus_write(2'd0, 10'b0100000000);          // standby, coding 0
        expect_now("R8 system standby drops enables");
        bus_write(2'd1, 10'h0F0);                 // main during standby
        bus_write(2'd0, 10'b0000000000);
        expect_now("R9 data stored during standby");
        bus_write(2'd0, 10'b1100100001);          // sub stby, mx 01
        expect_now("R8 channel standby drops sub enable");
        bus_write(2'd0, 10'b0011000001);          // main clr
        expect_now("R10 clear forces zero");
        bus_write(2'd0, 10'b0001000001);          // main unclear
        expect_now("R10 stored code restored");
        bus_write(2'd0, 10'b1000000000);          // power-down
        expect_now("R8 power-down drops enables");
        bus_write(2'd0, 10'b0000000000);
        bus_write(2'd0, 10'b1000000001);          // sub awake, sel=sub
        bus_write(2'd0, 10'b0010000010);          // byte mode, DB1=1 ignored
        expect_now("R5 byte mode entered via DB0=0");
        bus_write(2'd0, 10'b0001100011);          // DB0=1 ctl: main mx=11, sel kept
        expect_now("R5 R6 byte-mode channel control");
        bus_write(2'd1, 10'b1010101100);          // main hi = 0xAB
        expect_now("R6 R12 main high byte only");
        bus_write(2'd1, 10'b0000001111);          // sub lo = 11
        expect_now("R6 R12 sub low bits only");
        bus_write(2'd1, 10'b0000000110);          // main lo = 01
        expect_now("R12 main low bits keep high byte");
        bus_write(2'd0, 10'b0000000000);          // back to full width
        bus_write(2'd1, 10'h155);                 // goes to sel (sub)
        expect_now("R5 R6 full width restored, select unchanged");

        while (sbq.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule